// File: doc/BRIEF.md
# Clamped-Amount Left Shift Unit

This block executes one instruction: a logical left shift of a general register by an immediate amount. It sits in a small 16-bit core whose eight general registers (r0 to r7) are 24 bits wide. The block holds that register file and the four condition flags. An accepted instruction reads its destination register and turns the immediate into a shift distance. Distances are quantised: 0 to 3 exactly, 4 to 7 become 4, and 8 or more become 8. The low 16 bits are shifted with zero fill, the upper byte is cleared, the result is written back, and the carry, zero and negative flags are updated. The whole operation takes one clock.

An immediate-extension prefix can widen the 7-bit immediate to 20 or 24 bits. The wider value goes through the same amount mapping, so any non-zero upper part clamps the shift to 8. An instruction flagged as sitting in a delayed slot ignores any pending extension. A plain register-load port and a flag-load port let the surrounding core set up state. A combinational read port brings out any register.

The instruction interface uses valid/ready. `ins_ready` is low only while reset is held, so the block never applies back-pressure once reset is released. An instruction is accepted in every cycle where `ins_valid` and `ins_ready` are both high. The load ports are plain strobes.

Top module: `shl_exec_unit`

## Requirements
- R1: The shift distance from the effective immediate is that value when it is 0 to 3, 4 when it is 4 to 7, and 8 when it is 8 or more.
- R2: The written result has bits 15:0 equal to the low 16 bits of the old register shifted left by the distance with zeros entering at bit 0, and bits 23:16 equal to zero, including for a distance of 0.
- R3: Only the register chosen by the 3-bit `ins_rd` field (0 = r0 … 7 = r7) is written by a shift; all other registers keep their contents.
- R4: An instruction accepted at a clock edge has its result visible on `rd_data` and its flags on the flag outputs immediately after that same edge.
- R5: With `ins_ext_mode` = 1 the effective immediate is {`ins_ext_hi[12:0]`, `ins_imm7`}; with mode 2 it is {`ins_ext_hi[16:0]`, `ins_imm7`}; with mode 0 or 3 it is `ins_imm7` alone.
- R6: When `ins_delay` is 1, `ins_ext_mode` and `ins_ext_hi` have no effect and the effective immediate is `ins_imm7`.
- R7: After a shift, `flag_z` is 1 exactly when result bits 15:0 are all zero, and `flag_n` equals result bit 15.
- R8: After a shift of distance d > 0, `flag_c` equals bit (16 − d) of the old low 16 bits, which is the last bit shifted out of bit 15; for d = 0 `flag_c` is unchanged.
- R9: A shift leaves `flag_v` unchanged.
- R10: Synchronous active-high `rst` clears all eight registers and all four flags to zero, and `ins_ready` is low while `rst` is high.
- R11: `ld_valid` writes `ld_data` to register `ld_sel`; if an accepted shift targets the same register in the same cycle, the shift result is written instead.
- R12: `flg_ld_valid` loads {C,V,Z,N} from `flg_ld_data[3:0]` (bit 3 = C, bit 2 = V, bit 1 = Z, bit 0 = N) unless a shift is accepted in the same cycle, in which case the flag load has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ins_valid | input | 1 | Shift instruction present |
| ins_ready | output | 1 | Instruction can be accepted (low during reset) |
| ins_rd | input | 3 | Destination register index |
| ins_imm7 | input | 7 | Unsigned base immediate |
| ins_delay | input | 1 | Instruction is in a delayed slot |
| ins_ext_mode | input | 2 | Extension prefix: 0 none, 1 to 20 bits, 2 to 24 bits, 3 none |
| ins_ext_hi | input | 17 | Upper immediate bits supplied by the prefix |
| ld_valid | input | 1 | Register load strobe |
| ld_sel | input | 3 | Register load index |
| ld_data | input | 24 | Register load value |
| flg_ld_valid | input | 1 | Flag load strobe |
| flg_ld_data | input | 4 | Flag load value {C,V,Z,N} |
| rd_sel | input | 3 | Read port index |
| rd_data | output | 24 | Contents of register `rd_sel` (combinational) |
| flag_c | output | 1 | Carry flag |
| flag_v | output | 1 | Overflow flag |
| flag_z | output | 1 | Zero flag |
| flag_n | output | 1 | Negative flag |

## Verification
Each result passes through exactly one register, the register file entry or the flag register. Stimulus is applied at a falling edge and accepted at the next rising edge. The written register and the flags are therefore due on the ports at the falling edge after that one, and the bench samples them there. The read port is combinational, so the bench sets `rd_sel` at that same falling edge and samples after a short settle delay. Register loads, flag loads and reset follow the same one-edge timing. Untouched registers are read back only after the shift has been committed.

// File: rtl/shl_pkg.sv
package shl_pkg;
  localparam int DATA_W      = 24;
  localparam int OP_W        = 16;
  localparam int NREG        = 8;
  localparam int IMM_W       = 7;
  localparam int EXT_HI_W    = 17;
  localparam int EXT_SHORT_W = 13;
  localparam int MID_AMT     = 4;
  localparam int MAX_AMT     = 8;
  localparam int SEL_W       = $clog2(NREG);
  localparam int EFF_W       = IMM_W + EXT_HI_W;
  localparam int AMT_W       = $clog2(MAX_AMT + 1);

  typedef enum logic [1:0] {
    EXT_NONE  = 2'd0,
    EXT_SHORT = 2'd1,
    EXT_LONG  = 2'd2,
    EXT_RSVD  = 2'd3
  } ext_mode_e;

  typedef struct packed {
    logic c;
    logic v;
    logic z;
    logic n;
  } flags_t;
endpackage

// File: rtl/shl_decode.sv
module shl_decode
  import shl_pkg::*;
#(
  parameter int P_IMM_W       = IMM_W,
  parameter int P_EXT_HI_W    = EXT_HI_W,
  parameter int P_EXT_SHORT_W = EXT_SHORT_W,
  parameter int P_MID_AMT     = MID_AMT,
  parameter int P_MAX_AMT     = MAX_AMT,
  localparam int L_EFF_W      = P_IMM_W + P_EXT_HI_W,
  localparam int L_AMT_W      = $clog2(P_MAX_AMT + 1)
) (
  input  logic [P_IMM_W-1:0]    imm,
  input  logic                  in_delay,
  input  logic [1:0]            ext_mode,
  input  logic [P_EXT_HI_W-1:0] ext_hi,
  output logic [L_EFF_W-1:0]    eff_imm,
  output logic [L_AMT_W-1:0]    amt
);
  ext_mode_e mode_q;
  logic      use_ext;

  assign mode_q  = ext_mode_e'(ext_mode);
  // a delayed-slot instruction cannot carry a prefix
  assign use_ext = !in_delay;

  always_comb begin
    eff_imm = '0;
    eff_imm[P_IMM_W-1:0] = imm;
    if (use_ext) begin
      unique case (mode_q)
        EXT_SHORT: eff_imm[P_IMM_W +: P_EXT_SHORT_W] = ext_hi[P_EXT_SHORT_W-1:0];
        EXT_LONG:  eff_imm[P_IMM_W +: P_EXT_HI_W]    = ext_hi;
        default:   eff_imm[P_IMM_W-1:0]              = imm;
      endcase
    end
  end

  // quantise the distance: small values exact, middle band and above clamp
  always_comb begin
    if (eff_imm >= L_EFF_W'(P_MAX_AMT))
      amt = L_AMT_W'(P_MAX_AMT);
    else if (eff_imm >= L_EFF_W'(P_MID_AMT))
      amt = L_AMT_W'(P_MID_AMT);
    else
      amt = eff_imm[L_AMT_W-1:0];
  end
endmodule

// File: rtl/shl_datapath.sv
module shl_datapath
  import shl_pkg::*;
#(
  parameter int P_DATA_W  = DATA_W,
  parameter int P_OP_W    = OP_W,
  parameter int P_MAX_AMT = MAX_AMT,
  localparam int L_AMT_W  = $clog2(P_MAX_AMT + 1),
  localparam int L_TOP_W  = P_DATA_W - P_OP_W
) (
  input  logic [P_DATA_W-1:0] src,
  input  logic [L_AMT_W-1:0]  amt,
  input  logic                c_in,
  output logic [P_DATA_W-1:0] res,
  output logic                c_out,
  output logic                z_out,
  output logic                n_out
);
  logic [P_OP_W-1:0] low;
  logic [P_OP_W-1:0] shifted;
  logic [P_MAX_AMT:0] carry_pick;

  assign low     = src[P_OP_W-1:0];
  assign shifted = low << amt;

  // carry candidate per distance; index 0 keeps the old carry
  assign carry_pick[0] = c_in;
  for (genvar k = 1; k <= P_MAX_AMT; k++) begin : g_carry
    assign carry_pick[k] = low[P_OP_W-k];
  end

  always_comb begin
    c_out = c_in;
    for (int k = 0; k <= P_MAX_AMT; k++) begin
      if (amt == L_AMT_W'(k)) c_out = carry_pick[k];
    end
  end

  assign res   = {{L_TOP_W{1'b0}}, shifted};
  assign z_out = (shifted == '0);
  assign n_out = shifted[P_OP_W-1];
endmodule

// File: rtl/shl_regfile.sv
module shl_regfile
  import shl_pkg::*;
#(
  parameter int P_DATA_W = DATA_W,
  parameter int P_NREG   = NREG,
  localparam int L_SEL_W = $clog2(P_NREG)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                sh_we,
  input  logic [L_SEL_W-1:0]  sh_sel,
  input  logic [P_DATA_W-1:0] sh_data,
  input  logic                ld_we,
  input  logic [L_SEL_W-1:0]  ld_sel,
  input  logic [P_DATA_W-1:0] ld_data,
  input  logic [L_SEL_W-1:0]  src_sel,
  output logic [P_DATA_W-1:0] src_data,
  input  logic [L_SEL_W-1:0]  rd_sel,
  output logic [P_DATA_W-1:0] rd_data
);
  logic [P_DATA_W-1:0] regs [P_NREG];

  for (genvar i = 0; i < P_NREG; i++) begin : g_entry
    logic hit_sh;
    logic hit_ld;
    assign hit_sh = sh_we && (sh_sel == L_SEL_W'(i));
    assign hit_ld = ld_we && (ld_sel == L_SEL_W'(i));
    always_ff @(posedge clk) begin
      if (rst)         regs[i] <= '0;
      else if (hit_sh) regs[i] <= sh_data;   // shift has priority
      else if (hit_ld) regs[i] <= ld_data;
    end
  end

  assign src_data = regs[src_sel];
  assign rd_data  = regs[rd_sel];
endmodule

// File: rtl/shl_exec_unit.sv
module shl_exec_unit
  import shl_pkg::*;
#(
  parameter int P_DATA_W = DATA_W,
  parameter int P_OP_W   = OP_W,
  parameter int P_NREG   = NREG,
  parameter int P_IMM_W  = IMM_W,
  parameter int P_EXT_W  = EXT_HI_W,
  localparam int L_SEL_W = $clog2(P_NREG)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                ins_valid,
  output logic                ins_ready,
  input  logic [L_SEL_W-1:0]  ins_rd,
  input  logic [P_IMM_W-1:0]  ins_imm7,
  input  logic                ins_delay,
  input  logic [1:0]          ins_ext_mode,
  input  logic [P_EXT_W-1:0]  ins_ext_hi,
  input  logic                ld_valid,
  input  logic [L_SEL_W-1:0]  ld_sel,
  input  logic [P_DATA_W-1:0] ld_data,
  input  logic                flg_ld_valid,
  input  logic [3:0]          flg_ld_data,
  input  logic [L_SEL_W-1:0]  rd_sel,
  output logic [P_DATA_W-1:0] rd_data,
  output logic                flag_c,
  output logic                flag_v,
  output logic                flag_z,
  output logic                flag_n
);
  localparam int L_EFF_W = P_IMM_W + P_EXT_W;
  localparam int L_AMT_W = AMT_W;

  logic                fire;
  logic [L_EFF_W-1:0]  dec_eff;
  logic [L_AMT_W-1:0]  dec_amt;
  logic [P_DATA_W-1:0] src_data;
  logic [P_DATA_W-1:0] wb_data;
  logic                nxt_c;
  logic                nxt_z;
  logic                nxt_n;
  flags_t              flags_q;

  assign ins_ready = !rst;
  assign fire      = ins_valid && ins_ready;

  shl_decode #(
    .P_IMM_W    (P_IMM_W),
    .P_EXT_HI_W (P_EXT_W)
  ) u_decode (
    .imm      (ins_imm7),
    .in_delay (ins_delay),
    .ext_mode (ins_ext_mode),
    .ext_hi   (ins_ext_hi),
    .eff_imm  (dec_eff),
    .amt      (dec_amt)
  );

  shl_regfile #(
    .P_DATA_W (P_DATA_W),
    .P_NREG   (P_NREG)
  ) u_regs (
    .clk      (clk),
    .rst      (rst),
    .sh_we    (fire),
    .sh_sel   (ins_rd),
    .sh_data  (wb_data),
    .ld_we    (ld_valid),
    .ld_sel   (ld_sel),
    .ld_data  (ld_data),
    .src_sel  (ins_rd),
    .src_data (src_data),
    .rd_sel   (rd_sel),
    .rd_data  (rd_data)
  );

  shl_datapath #(
    .P_DATA_W (P_DATA_W),
    .P_OP_W   (P_OP_W)
  ) u_dp (
    .src   (src_data),
    .amt   (dec_amt),
    .c_in  (flags_q.c),
    .res   (wb_data),
    .c_out (nxt_c),
    .z_out (nxt_z),
    .n_out (nxt_n)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      flags_q <= '0;
    end else if (fire) begin
      flags_q.c <= nxt_c;
      flags_q.z <= nxt_z;
      flags_q.n <= nxt_n;
    end else if (flg_ld_valid) begin
      flags_q <= flags_t'(flg_ld_data);
    end
  end

  assign flag_c = flags_q.c;
  assign flag_v = flags_q.v;
  assign flag_z = flags_q.z;
  assign flag_n = flags_q.n;
endmodule

// File: rtl/shl_exec_checker.sv
module shl_exec_checker
  import shl_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              ins_valid,
  input logic              ins_ready,
  input logic [IMM_W-1:0]  ins_imm7,
  input logic              ins_delay,
  input logic [AMT_W-1:0]  amt,
  input logic [DATA_W-1:0] wb_data,
  input logic              flag_c,
  input logic              flag_v,
  input logic              flag_z,
  input logic              flag_n
);
  logic fire;
  assign fire = ins_valid && ins_ready;

  a_r10_reset_flags: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!flag_c && !flag_v && !flag_z && !flag_n));

  a_r2_upper_zero: assert property (@(posedge clk) disable iff (rst)
    fire |-> (wb_data[DATA_W-1:OP_W] == '0));

  a_r6_delay_small: assert property (@(posedge clk) disable iff (rst)
    (fire && ins_delay && ins_imm7 < IMM_W'(MID_AMT)) |-> (amt == AMT_W'(ins_imm7)));

  a_r1_delay_clamp: assert property (@(posedge clk) disable iff (rst)
    (fire && ins_delay && ins_imm7 >= IMM_W'(MAX_AMT)) |-> (amt == AMT_W'(MAX_AMT)));

  a_r9_no_overflow: assert property (@(posedge clk) disable iff (rst)
    fire |=> (flag_v == $past(flag_v)));

  a_r8_carry_hold: assert property (@(posedge clk) disable iff (rst)
    (fire && amt == '0) |=> (flag_c == $past(flag_c)));

  a_r7_flags_follow: assert property (@(posedge clk) disable iff (rst)
    fire |=> (flag_n == $past(wb_data[OP_W-1]) &&
              flag_z == ($past(wb_data[OP_W-1:0]) == '0)));
endmodule

bind shl_exec_unit shl_exec_checker u_chk (
  .clk       (clk),
  .rst       (rst),
  .ins_valid (ins_valid),
  .ins_ready (ins_ready),
  .ins_imm7  (ins_imm7),
  .ins_delay (ins_delay),
  .amt       (dec_amt),
  .wb_data   (wb_data),
  .flag_c    (flag_c),
  .flag_v    (flag_v),
  .flag_z    (flag_z),
  .flag_n    (flag_n)
);

// File: tb/shl_exec_unit_bench.sv
`timescale 1ns/1ps
module shl_exec_unit_bench;
  logic        clk = 1'b0;
  logic        rst;
  logic        ins_valid, ins_ready, ins_delay;
  logic [2:0]  ins_rd;
  logic [6:0]  ins_imm7;
  logic [1:0]  ins_ext_mode;
  logic [16:0] ins_ext_hi;
  logic        ld_valid;
  logic [2:0]  ld_sel;
  logic [23:0] ld_data;
  logic        flg_ld_valid;
  logic [3:0]  flg_ld_data;
  logic [2:0]  rd_sel;
  logic [23:0] rd_data;
  logic        flag_c, flag_v, flag_z, flag_n;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [23:0] m_reg [8];
  logic [3:0]  m_flg;

  always #5 clk = ~clk;

  shl_exec_unit u_shl_exec_unit (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    ins_valid = 0; ld_valid = 0; flg_ld_valid = 0;
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk); idle();
  endtask

  task automatic load(input int r, input logic [23:0] v);
    ld_valid = 1; ld_sel = 3'(r); ld_data = v;
    step();
    m_reg[r] = v;
  endtask

  task automatic load_flags(input logic [3:0] f);
    flg_ld_valid = 1; flg_ld_data = f;
    step();
    m_flg = f;
  endtask

  task automatic read_check(input int r, input string req);
    rd_sel = 3'(r); #1;
    chk(req, 32'(rd_data), 32'(m_reg[r]));
  endtask

  task automatic flag_check(input string req);
    chk(req, {28'd0, flag_c, flag_v, flag_z, flag_n}, {28'd0, m_flg});
  endtask

  function automatic int exp_amt(input logic [6:0] imm, input logic dly,
                                 input logic [1:0] md, input logic [16:0] hi);
    logic [23:0] e;
    e = {17'd0, imm};
    if (!dly && md == 2'd1) e = {4'd0, hi[12:0], imm};
    if (!dly && md == 2'd2) e = {hi, imm};
    if (e >= 24'd8) return 8;
    if (e >= 24'd4) return 4;
    return int'(e);
  endfunction

  task automatic shift(input int r, input logic [6:0] imm, input logic dly,
                       input logic [1:0] md, input logic [16:0] hi, input string req);
    int a;
    logic [15:0] lo, res;
    a  = exp_amt(imm, dly, md, hi);
    lo = m_reg[r][15:0];
    res = lo << a;
    if (a > 0) m_flg[3] = lo[16-a];
    m_flg[1] = (res == 16'd0);
    m_flg[0] = res[15];
    m_reg[r] = {8'd0, res};
    ins_valid = 1; ins_rd = 3'(r); ins_imm7 = imm; ins_delay = dly;
    ins_ext_mode = md; ins_ext_hi = hi;
    step();
    read_check(r, req);
    flag_check(req);
  endtask

  initial begin
    logic [23:0] pats [4];
    logic [16:0] his [4];
    pats[0] = 24'hFF_8001; pats[1] = 24'hA5_C3F0;
    pats[2] = 24'h12_0000 | 24'h0001; pats[3] = 24'h7E_FFFF;
    his[0] = 17'd0; his[1] = 17'd1; his[2] = 17'h1E000; his[3] = 17'h00800;
    idle();
    rst = 1; ins_rd = 0; ins_imm7 = 0; ins_delay = 0; ins_ext_mode = 0;
    ins_ext_hi = 0; ld_sel = 0; ld_data = 0; flg_ld_data = 0; rd_sel = 0;
    for (int i = 0; i < 8; i++) m_reg[i] = '0;
    m_flg = '0;
    @(negedge clk); @(negedge clk);
    chk("R10 ready low in reset", 32'(ins_ready), 32'd0);
    for (int i = 0; i < 8; i++) read_check(i, "R10 register reset");
    flag_check("R10 flag reset");
    rst = 0; #1;
    chk("R10 ready after reset", 32'(ins_ready), 32'd1);
    @(negedge clk);

    // R12 flag load, then V held across shifts
    load_flags(4'b0100);
    flag_check("R12 flag load");

    // R1 R2 R7 R8 R9: full imm7 sweep, no extension, several patterns
    for (int p = 0; p < 4; p++) begin
      for (int imm = 0; imm < 128; imm++) begin
        int r;
        r = (imm + p) % 8;
        load(r, pats[p] ^ 24'(imm * 24'h000101));
        shift(r, 7'(imm), 1'b0, 2'd0, 17'h1FFFF, "R1 R2 R7 R8 R9 plain sweep");
      end
    end

    // R3 untouched registers keep their values
    for (int i = 0; i < 8; i++) load(i, 24'h5A0000 | 24'(i * 24'h1111));
    shift(3, 7'd2, 1'b0, 2'd0, 17'd0, "R3 target");
    for (int i = 0; i < 8; i++) read_check(i, "R3 others unchanged");

    // R5 R6: extension modes, prefix patterns, delayed slot
    for (int md = 0; md < 4; md++)
      for (int h = 0; h < 4; h++)
        for (int dl = 0; dl < 2; dl++)
          for (int imm = 0; imm < 10; imm++) begin
            load(5, 24'h33_9C3B ^ 24'(imm << 3));
            shift(5, 7'(imm), 1'(dl), 2'(md), his[h],
                  dl ? "R6 delay ignores ext" : "R5 extension mapping");
          end

    // R8 zero distance keeps carry both ways
    load_flags(4'b1000);
    load(1, 24'hFF_0000);
    shift(1, 7'd0, 1'b0, 2'd0, 17'd0, "R8 carry held at d=0, R2 top cleared");
    load_flags(4'b0110);
    shift(1, 7'd0, 1'b0, 2'd0, 17'd0, "R8 carry held clear at d=0");

    // R11 shift wins a same-register load; different register both land
    load(2, 24'h00_0003);
    ld_valid = 1; ld_sel = 3'd2; ld_data = 24'hABCDEF;
    shift(2, 7'd1, 1'b0, 2'd0, 17'd0, "R11 shift beats load");
    ld_valid = 1; ld_sel = 3'd6; ld_data = 24'h123456;
    m_reg[6] = 24'h123456;
    shift(2, 7'd1, 1'b0, 2'd0, 17'd0, "R11 shift alongside load");
    read_check(6, "R11 load alongside shift");

    // R12 flag load ignored when a shift is accepted; R4 one-cycle result
    flg_ld_valid = 1; flg_ld_data = 4'b1111;
    load(7, 24'h00_4000);
    flg_ld_valid = 1; flg_ld_data = 4'b1111;
    shift(7, 7'd2, 1'b0, 2'd0, 17'd0, "R12 flag load ignored, R4 timing");
    load_flags(m_flg);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule